// File: doc/BRIEF.md
# Floating-Point Condition Code Generator

This block turns the outcome of a floating-point compare, or the examination of one 80-bit extended-precision register, into condition bits. A compare result arrives as a two-bit code and is written either into the four condition bits of the 16-bit floating-point status word or into the zero, parity and carry bits of an integer flags word. For an examine, the block takes the sign, 15-bit exponent, 64-bit mantissa and empty tag of a register and records its class in the status word.

The block is purely combinational. The compare itself, exception signalling and the register file are handled elsewhere. It only rewrites the bits that its operation owns, and every other bit of both words passes through unchanged. No data stream crosses this block, so it has no valid/ready handshake. The caller presents its words and reads the updated words back in the same cycle.

Top module: `fpcc_gen`

## Requirements
- R1: Operation code `op` is 2 bits: 0 idle, 1 compare into status, 2 compare into flags, 3 examine. The compare code `cmp_res` is 2 bits: 0 less, 1 equal, 2 greater, 3 unordered. Status condition bits sit at C0 = bit 8, C1 = bit 9, C2 = bit 10, C3 = bit 14.
- R2: In compare-into-status, bits 14, 10 and 8 are cleared and then set as follows: less gives 0x0100, equal gives 0x4000, greater gives 0x0000, unordered gives 0x4500.
- R3: In compare-into-status, status bits outside mask 0x4500 and the whole flags word pass through unchanged.
- R4: In compare-into-flags, with CF = bit 0, PF = bit 2, ZF = bit 6 by default, those three bits are cleared and then set as follows: CF for less, ZF for equal, none for greater, and all three for unordered. The other flag bits and the whole status word pass through unchanged.
- R5: In examine, mask 0x4700 is cleared and C1 (0x0200) is set when the sign is 1 and the entry is not empty. The other status bits and the whole flags word pass through unchanged.
- R6: In examine with exponent 0x7FFF, a mantissa of exactly 0x8000000000000000 sets 0x0500 (infinity). Any other mantissa sets 0x0100 (NaN).
- R7: In examine with exponent 0, a zero mantissa sets 0x4000 (zero). A nonzero mantissa sets 0x4400 (denormal).
- R8: In examine with an exponent that is neither 0 nor 0x7FFF, 0x0400 (normal) is set whatever the mantissa.
- R9: In examine with the empty tag set, the result is 0x4100 whatever the sign, exponent and mantissa.
- R10: In idle, both words pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 2 | Operation select (R1 encoding) |
| cmp_res | input | 2 | Compare outcome code (R1 encoding) |
| x_sign | input | 1 | Sign of the examined value |
| x_exp | input | EXP_W (15) | Biased exponent of the examined value |
| x_mant | input | MANT_W (64) | Mantissa including explicit integer bit |
| x_empty | input | 1 | Empty tag of the examined register |
| sw_in | input | 16 | Current status word |
| fl_in | input | FL_W (32) | Current integer flags word |
| sw_out | output | 16 | Updated status word |
| fl_out | output | FL_W (32) | Updated integer flags word |

## Verification
The sweeps target the edges between classes. An exponent of 0x7FFF with a zero mantissa must read as NaN, not infinity. The same exponent with a mantissa whose top two bits are set must also read as NaN, so a design that only tests the top bit would call it infinity. Exponents 1 and 0x7FFE must read as normal, so an off-by-one exponent compare would report a denormal or an infinity. An empty entry with a negative infinity inside must give exactly 0x4100: a design that lets the stored contents or the sign leak through would set C2 or C1. Compare and examine run with status words whose other bits are all ones, so that a mask that is too wide, such as clearing C1 on a compare, shows up, and the word that is not targeted is checked for being left alone.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  localparam int SW_W   = 16;
  localparam int C0_POS = 8;
  localparam int C1_POS = 9;
  localparam int C2_POS = 10;
  localparam int C3_POS = 14;

  typedef enum logic [1:0] {
    CMP_LT = 2'd0,
    CMP_EQ = 2'd1,
    CMP_GT = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_CMP_SW = 2'd1,
    OP_CMP_FL = 2'd2,
    OP_EXAM   = 2'd3
  } op_e;

  localparam int CL_NAN   = 0;
  localparam int CL_INF   = 1;
  localparam int CL_NORM  = 2;
  localparam int CL_ZERO  = 3;
  localparam int CL_DEN   = 4;
  localparam int CL_EMPTY = 5;
  localparam int CL_N     = 6;

  localparam logic [SW_W-1:0] BIT_C0 = SW_W'(1) << C0_POS;
  localparam logic [SW_W-1:0] BIT_C1 = SW_W'(1) << C1_POS;
  localparam logic [SW_W-1:0] BIT_C2 = SW_W'(1) << C2_POS;
  localparam logic [SW_W-1:0] BIT_C3 = SW_W'(1) << C3_POS;
  localparam logic [SW_W-1:0] CMP_MASK  = BIT_C3 | BIT_C2 | BIT_C0;
  localparam logic [SW_W-1:0] EXAM_MASK = CMP_MASK | BIT_C1;
endpackage

// File: rtl/fpcc_cmp_sw.sv
module fpcc_cmp_sw
  import fpcc_pkg::*;
(
  input  cmp_res_e          res,
  input  logic [SW_W-1:0]   sw_in,
  output logic [SW_W-1:0]   sw_out
);
  logic [SW_W-1:0] cc;

  always_comb begin
    unique case (res)
      CMP_LT:  cc = BIT_C0;
      CMP_EQ:  cc = BIT_C3;
      CMP_GT:  cc = '0;
      default: cc = BIT_C3 | BIT_C2 | BIT_C0;
    endcase
    sw_out = (sw_in & ~CMP_MASK) | cc;
  end

  always_comb begin
    // R3
    sw_cmp_keep_chk: assert ((sw_out & ~CMP_MASK) == (sw_in & ~CMP_MASK))
      else $error("compare touched bits outside the condition mask");
    // R2
    sw_cmp_c1_chk: assert (sw_out[C1_POS] == sw_in[C1_POS])
      else $error("compare changed C1");
  end
endmodule

// File: rtl/fpcc_cmp_fl.sv
module fpcc_cmp_fl
  import fpcc_pkg::*;
#(
  parameter int FL_W   = 32,
  parameter int CF_POS = 0,
  parameter int PF_POS = 2,
  parameter int ZF_POS = 6
) (
  input  cmp_res_e          res,
  input  logic [FL_W-1:0]   fl_in,
  output logic [FL_W-1:0]   fl_out
);
  localparam logic [FL_W-1:0] F_CF = FL_W'(1) << CF_POS;
  localparam logic [FL_W-1:0] F_PF = FL_W'(1) << PF_POS;
  localparam logic [FL_W-1:0] F_ZF = FL_W'(1) << ZF_POS;
  localparam logic [FL_W-1:0] F_MASK = F_CF | F_PF | F_ZF;

  logic [FL_W-1:0] cc;

  always_comb begin
    unique case (res)
      CMP_LT:  cc = F_CF;
      CMP_EQ:  cc = F_ZF;
      CMP_GT:  cc = '0;
      default: cc = F_MASK;
    endcase
    fl_out = (fl_in & ~F_MASK) | cc;
  end

  always_comb begin
    // R4
    fl_cmp_keep_chk: assert ((fl_out & ~F_MASK) == (fl_in & ~F_MASK))
      else $error("flag compare touched other flag bits");
    // R4
    fl_cmp_pf_chk: assert (fl_out[PF_POS] == (fl_out[ZF_POS] & fl_out[CF_POS]))
      else $error("parity flag set without unordered pattern");
  end
endmodule

// File: rtl/fpcc_classify.sv
module fpcc_classify
  import fpcc_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int MANT_W = 64
) (
  input  logic              sign,
  input  logic [EXP_W-1:0]  expo,
  input  logic [MANT_W-1:0] mant,
  input  logic              empty,
  output logic [CL_N-1:0]   cls,
  output logic              neg
);
  localparam logic [MANT_W-1:0] INF_MANT = {1'b1, {(MANT_W-1){1'b0}}};

  logic exp_max, exp_zero, mant_zero, mant_inf, live;

  always_comb begin
    exp_max   = &expo;
    exp_zero  = ~|expo;
    mant_zero = ~|mant;
    mant_inf  = (mant == INF_MANT);
    live      = ~empty;
    cls           = '0;
    cls[CL_EMPTY] = empty;
    cls[CL_NAN]   = live & exp_max & ~mant_inf;
    cls[CL_INF]   = live & exp_max & mant_inf;
    cls[CL_ZERO]  = live & exp_zero & mant_zero;
    cls[CL_DEN]   = live & exp_zero & ~mant_zero;
    cls[CL_NORM]  = live & ~exp_max & ~exp_zero;
    neg           = live & sign;
  end
endmodule

// File: rtl/fpcc_exam_enc.sv
module fpcc_exam_enc
  import fpcc_pkg::*;
(
  input  logic [CL_N-1:0]  cls,
  input  logic             neg,
  input  logic [SW_W-1:0]  sw_in,
  output logic [SW_W-1:0]  sw_out
);
  logic [SW_W-1:0] cc;

  always_comb begin
    cc = '0;
    for (int i = 0; i < CL_N; i++) begin
      if (cls[i]) begin
        case (i)
          CL_NAN:   cc = cc | BIT_C0;
          CL_INF:   cc = cc | BIT_C2 | BIT_C0;
          CL_NORM:  cc = cc | BIT_C2;
          CL_ZERO:  cc = cc | BIT_C3;
          CL_DEN:   cc = cc | BIT_C3 | BIT_C2;
          default:  cc = cc | BIT_C3 | BIT_C0;
        endcase
      end
    end
    if (neg) cc = cc | BIT_C1;
    sw_out = (sw_in & ~EXAM_MASK) | cc;
  end

  always_comb begin
    // R6
    cls_onehot_chk: assert ($onehot(cls))
      else $error("examine class not one-hot");
    // R9
    exam_no_triple_chk: assert (!(sw_out[C3_POS] & sw_out[C2_POS] & sw_out[C0_POS]))
      else $error("examine produced the unordered pattern");
    // R5
    exam_keep_chk: assert ((sw_out & ~EXAM_MASK) == (sw_in & ~EXAM_MASK))
      else $error("examine touched bits outside its mask");
  end
endmodule

// File: rtl/fpcc_gen.sv
module fpcc_gen
  import fpcc_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int MANT_W = 64,
  parameter int FL_W   = 32,
  parameter int CF_POS = 0,
  parameter int PF_POS = 2,
  parameter int ZF_POS = 6
) (
  input  logic [1:0]        op,
  input  logic [1:0]        cmp_res,
  input  logic              x_sign,
  input  logic [EXP_W-1:0]  x_exp,
  input  logic [MANT_W-1:0] x_mant,
  input  logic              x_empty,
  input  logic [15:0]       sw_in,
  input  logic [FL_W-1:0]   fl_in,
  output logic [15:0]       sw_out,
  output logic [FL_W-1:0]   fl_out
);
  op_e             op_q;
  cmp_res_e        res;
  logic [SW_W-1:0] sw_cmp, sw_exam;
  logic [FL_W-1:0] fl_cmp;
  logic [CL_N-1:0] cls;
  logic            neg;

  assign op_q = op_e'(op);
  assign res  = cmp_res_e'(cmp_res);

  fpcc_cmp_sw u_cmp_sw (
    .res    (res),
    .sw_in  (sw_in),
    .sw_out (sw_cmp)
  );

  fpcc_cmp_fl #(
    .FL_W(FL_W), .CF_POS(CF_POS), .PF_POS(PF_POS), .ZF_POS(ZF_POS)
  ) u_cmp_fl (
    .res    (res),
    .fl_in  (fl_in),
    .fl_out (fl_cmp)
  );

  fpcc_classify #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_cls (
    .sign  (x_sign),
    .expo  (x_exp),
    .mant  (x_mant),
    .empty (x_empty),
    .cls   (cls),
    .neg   (neg)
  );

  fpcc_exam_enc u_enc (
    .cls    (cls),
    .neg    (neg),
    .sw_in  (sw_in),
    .sw_out (sw_exam)
  );

  always_comb begin
    sw_out = sw_in;
    fl_out = fl_in;
    unique case (op_q)
      OP_CMP_SW: sw_out = sw_cmp;
      OP_CMP_FL: fl_out = fl_cmp;
      OP_EXAM:   sw_out = sw_exam;
      default:   ;
    endcase
  end

  always_comb begin
    // R10
    idle_pass_chk: assert (op_q != OP_IDLE || (sw_out == sw_in && fl_out == fl_in))
      else $error("idle altered a word");
    // R3
    sw_cmp_flags_chk: assert (op_q != OP_CMP_SW || fl_out == fl_in)
      else $error("status compare altered flags");
    // R4
    fl_cmp_status_chk: assert (op_q != OP_CMP_FL || sw_out == sw_in)
      else $error("flag compare altered status");
    // R5
    exam_c1_chk: assert (op_q != OP_EXAM || sw_out[C1_POS] == (x_sign & ~x_empty))
      else $error("examine C1 does not follow sign");
    // R9
    exam_empty_chk: assert (op_q != OP_EXAM || !x_empty ||
                            (sw_out & EXAM_MASK) == (BIT_C3 | BIT_C0))
      else $error("empty entry not reported as empty");
  end
endmodule

// File: tb/tb_fpcc_gen.sv
module tb_fpcc_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  op, cmp_res;
  logic        x_sign, x_empty;
  logic [14:0] x_exp;
  logic [63:0] x_mant;
  logic [15:0] sw_in, sw_out;
  logic [31:0] fl_in, fl_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fpcc_gen dut (
    .op(op), .cmp_res(cmp_res), .x_sign(x_sign), .x_exp(x_exp),
    .x_mant(x_mant), .x_empty(x_empty), .sw_in(sw_in), .fl_in(fl_in),
    .sw_out(sw_out), .fl_out(fl_out)
  );

  function automatic logic [15:0] exp_sw_cmp(input logic [1:0] r, input logic [15:0] s);
    logic [15:0] v;
    v = s & 16'hBAFF;
    case (r)
      2'd0: v = v + 16'h0100;
      2'd1: v = v + 16'h4000;
      2'd2: v = v;
      default: v = v + 16'h4500;
    endcase
    return v;
  endfunction

  function automatic logic [31:0] exp_fl_cmp(input logic [1:0] r, input logic [31:0] f);
    logic [31:0] v;
    v = f & ~32'd69;
    case (r)
      2'd0: v = v + 32'd1;
      2'd1: v = v + 32'd64;
      2'd2: v = v;
      default: v = v + 32'd69;
    endcase
    return v;
  endfunction

  function automatic logic [15:0] exp_exam(input logic sg, input logic [14:0] e,
                                           input logic [63:0] m, input logic em,
                                           input logic [15:0] s);
    logic [15:0] v;
    v = s & 16'hB8FF;
    if (em) return v + 16'h4100;
    if (sg) v = v + 16'h0200;
    if (e == 15'h7FFF) v = v + ((m == 64'h8000_0000_0000_0000) ? 16'h0500 : 16'h0100);
    else if (e == 0) v = v + ((m == 0) ? 16'h4000 : 16'h4400);
    else v = v + 16'h0400;
    return v;
  endfunction

  task automatic check(input string req, input logic [15:0] es, input logic [31:0] ef);
    checks++;
    if (sw_out !== es || fl_out !== ef) begin
      fails++;
      $display("FAIL %s sw=%h exp_sw=%h fl=%h exp_fl=%h", req, sw_out, es, fl_out, ef);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [1:0] r, input logic sg,
                       input logic [14:0] e, input logic [63:0] m, input logic em,
                       input logic [15:0] s, input logic [31:0] f);
    @(posedge clk);
    op = o; cmp_res = r; x_sign = sg; x_exp = e; x_mant = m; x_empty = em;
    sw_in = s; fl_in = f;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] swp[4];
    logic [31:0] flp[4];
    logic [14:0] exps[6];
    logic [63:0] mants[5];
    swp = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A};
    flp = '{32'h0, 32'hFFFF_FFFF, 32'h0000_00BA, 32'h1234_5645};
    exps = '{15'h0000, 15'h0001, 15'h3FFF, 15'h7FFE, 15'h7FFF, 15'h2A55};
    mants = '{64'h0, 64'h1, 64'h8000_0000_0000_0000, 64'hC000_0000_0000_0000,
              64'h7FFF_FFFF_FFFF_FFFF};
    op = 0; cmp_res = 0; x_sign = 0; x_exp = 0; x_mant = 0; x_empty = 0;
    sw_in = 0; fl_in = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset-state", 16'h0, 32'h0);
    // R10 idle passes both words
    for (int p = 0; p < 4; p++) begin
      apply(2'd0, 2'd3, 1, 15'h7FFF, 0, 1, swp[p], flp[p]);
      check("R10", swp[p], flp[p]);
    end
    // R1 R2 R3 status compare, R4 flag compare
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 4; p++) begin
        apply(2'd1, r[1:0], 0, 0, 0, 0, swp[p], flp[p]);
        check("R2/R3", exp_sw_cmp(r[1:0], swp[p]), flp[p]);
        apply(2'd2, r[1:0], 0, 0, 0, 0, swp[p], flp[p]);
        check("R4", swp[p], exp_fl_cmp(r[1:0], flp[p]));
      end
    // R5 R6 R7 R8 R9 examine sweep
    for (int e = 0; e < 6; e++)
      for (int m = 0; m < 5; m++)
        for (int sg = 0; sg < 2; sg++)
          for (int em = 0; em < 2; em++)
            for (int p = 0; p < 2; p++) begin
              apply(2'd3, 2'd3, sg[0], exps[e], mants[m], em[0], swp[p+1], flp[p+1]);
              check(em ? "R9" : (exps[e] == 15'h7FFF ? "R6" :
                    (exps[e] == 0 ? "R7" : "R8")),
                    exp_exam(sg[0], exps[e], mants[m], em[0], swp[p+1]), flp[p+1]);
            end
    // R5 C1 follows sign on negative normal
    apply(2'd3, 0, 1, 15'h4000, 64'h8000_0000_0000_0000, 0, 16'h0000, 32'h0);
    check("R5", 16'h0600, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule